// File: doc/BRIEF.md
# Serial Line Modem-Control Unit

This block is the modem-control part of a serial port that plays the terminal side of a terminal-to-modem link. It drives two active-low handshake outputs, terminal-ready (DTR) and request-to-send (RTS). It also watches four active-low handshake inputs for level changes: clear-to-send (CTS), data-set-ready (DSR), carrier-detect (DCD) and ring (RI). Software switches DTR on and off with single-cycle command pulses. RTS follows the receiver enable with no software involvement.

Each of the four inputs passes through a synchronizer and then an edge detector. A change in either direction sets that input's change flag. The flag stays set until software reads the status. A per-flag mask selects which flags drive the interrupt line. The synchronized CTS also gates the transmitter: when the far end withdraws CTS, a character already being shifted out still finishes, and only then is the transmitter stopped. All of this is active only while the mode field holds the modem-mode code. In any other mode both outputs sit inactive, no changes are recorded and the transmitter is never held back.

Top module: `mdm_ctrl_top`

## Requirements
- R1: Modem mode is active only when `mode_i` equals 3. One clock edge after any other mode value is presented, `dtr_n_o` and `rts_n_o` are both high. Both are also high out of reset.
- R2: Outside modem mode, input level changes set no change flag. Entering modem mode with inputs that are already stable sets no flag either.
- R3: In modem mode, `dtr_on_i` drives `dtr_n_o` low at the next edge and `dtr_off_i` drives it high at the next edge. If both are given in the same cycle, off wins. With neither command, the level holds.
- R4: In modem mode, `rts_n_o` is low one edge after `rx_en_i` is high, and high one edge after it is low.
- R5: Bit mapping of `line_n_i` and `chg_o` is 0 = CTS, 1 = DSR, 2 = DCD, 3 = RI. A rising or falling level on an input bit sets the matching `chg_o` bit on the third rising edge after the change, and not earlier.
- R6: A set `chg_o` bit stays set until `stat_rd_i` is high at a clock edge. That edge clears it.
- R7: If a new change reaches a flag at the same edge as a status read, the flag stays set.
- R8: `irq_o` is high exactly when some bit of `chg_o & irq_en_i` is set.
- R9: In modem mode with no character in flight, `tx_allow_o` goes low on the third edge after CTS rises (inactive) and high on the third edge after CTS falls.
- R10: If CTS goes inactive while `tx_busy_i` is high, `tx_allow_o` stays high until `tx_busy_i` falls, and goes low at the edge after that.
- R11: Outside modem mode, `tx_allow_o` is high one edge later, whatever the CTS level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Port mode field; 3 selects modem mode |
| dtr_on_i | input | 1 | Command pulse: assert terminal-ready |
| dtr_off_i | input | 1 | Command pulse: deassert terminal-ready (dominant) |
| rx_en_i | input | 1 | Receiver enabled; drives RTS |
| stat_rd_i | input | 1 | Status read strobe; clears change flags |
| irq_en_i | input | 4 | Per-flag interrupt enable |
| line_n_i | input | 4 | Active-low handshake inputs {RI, DCD, DSR, CTS} |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| dtr_n_o | output | 1 | Terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| chg_o | output | 4 | Sticky change flags |
| irq_o | output | 1 | Interrupt request |
| tx_allow_o | output | 1 | Transmitter may run |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a four-bit mode field and the modem code 3. At this size every mode value, every input bit in both directions, and every pair of change pattern and interrupt mask (15 × 16) can be swept completely. The sweeps compute each expected value from the bit arithmetic. The fixed three-edge latency makes it possible to place a status read exactly on the edge where a new change lands. The bench also probes the edge one cycle before the flag is due.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned N_LINES  = 4;
  localparam int unsigned LINE_CTS = 0;
  localparam int unsigned LINE_DSR = 1;
  localparam int unsigned LINE_DCD = 2;
  localparam int unsigned LINE_RI  = 3;
  typedef logic [N_LINES-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= sh_d;
    end

    assign q_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/mdm_chg_stat.sv
module mdm_chg_stat #(
  parameter int unsigned WIDTH   = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] line_s_i,
  output logic [WIDTH-1:0] stat_o
);
  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] stat_q, stat_d;
  logic [WIDTH-1:0] edge_w;

  always_comb begin
    prev_d = line_s_i;
    edge_w = en_i ? (line_s_i ^ prev_q) : '0;
    stat_d = (stat_q & ~{WIDTH{rd_i}}) | edge_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= {WIDTH{RST_VAL}};
      stat_q <= '0;
    end else begin
      prev_q <= prev_d;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R6: without a read, no set flag is lost
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R2: outside modem mode a clear status stays clear
  assert_no_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && (stat_q == '0)) |=> (stat_q == '0));
endmodule

// File: rtl/mdm_tx_gate.sv
module mdm_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cts_n_s_i,
  input  logic busy_i,
  output logic allow_o
);
  logic allow_q, allow_d;

  always_comb begin
    allow_d = !en_i || !cts_n_s_i || (allow_q && busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allow_q <= 1'b1;
    else        allow_q <= allow_d;
  end

  assign allow_o = allow_q;

  // R10: a character in flight keeps the transmitter allowed
  assert_hold_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_q && busy_i) |=> allow_q);

  // R11: outside modem mode the gate opens
  assert_open_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> allow_q);
endmodule

// File: rtl/mdm_ctrl_top.sv
module mdm_ctrl_top
  import mdm_pkg::*;
#(
  parameter int unsigned MODE_W      = 4,
  parameter int unsigned MODEM_CODE  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dtr_on_i,
  input  logic              dtr_off_i,
  input  logic              rx_en_i,
  input  logic              stat_rd_i,
  input  logic [3:0]        irq_en_i,
  input  logic [3:0]        line_n_i,
  input  logic              tx_busy_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic [3:0]        chg_o,
  output logic              irq_o,
  output logic              tx_allow_o
);
  localparam logic [MODE_W-1:0] MODEM_SEL = MODE_W'(MODEM_CODE);

  logic      modem_on;
  logic      dtr_act_q, dtr_act_d;
  logic      rts_act_q, rts_act_d;
  line_vec_t line_s;
  line_vec_t stat;

  assign modem_on = (mode_i == MODEM_SEL);

  always_comb begin
    if (!modem_on)      dtr_act_d = 1'b0;
    else if (dtr_off_i) dtr_act_d = 1'b0;
    else if (dtr_on_i)  dtr_act_d = 1'b1;
    else                dtr_act_d = dtr_act_q;
    rts_act_d = modem_on && rx_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtr_act_q <= 1'b0;
      rts_act_q <= 1'b0;
    end else begin
      dtr_act_q <= dtr_act_d;
      rts_act_q <= rts_act_d;
    end
  end

  mdm_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_n_i), .q_o(line_s)
  );

  mdm_chg_stat #(.WIDTH(N_LINES), .RST_VAL(1'b1)) i_stat (
    .clk(clk), .rst_n(rst_n), .en_i(modem_on), .rd_i(stat_rd_i),
    .line_s_i(line_s), .stat_o(stat)
  );

  mdm_tx_gate i_gate (
    .clk(clk), .rst_n(rst_n), .en_i(modem_on), .cts_n_s_i(line_s[LINE_CTS]),
    .busy_i(tx_busy_i), .allow_o(tx_allow_o)
  );

  assign dtr_n_o = !dtr_act_q;
  assign rts_n_o = !rts_act_q;
  assign chg_o   = stat;
  assign irq_o   = |(stat & irq_en_i);

  // R3: disable dominates enable
  assert_dtr_off_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_on && dtr_off_i) |=> dtr_n_o);

  // R1: both outputs inactive after a non-modem cycle
  assert_inactive_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_on |=> (dtr_n_o && rts_n_o));

  // R8: no interrupt without a flag behind it
  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (chg_o != 4'h0));
endmodule

// File: tb/test_mdm_ctrl_top.sv
`timescale 1ns/1ps
module test_mdm_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode;
  logic       dtr_on, dtr_off, rx_en, rd, busy;
  logic [3:0] mask, lines;
  logic       dtr_n, rts_n, irq, allow;
  logic [3:0] chg;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  mdm_ctrl_top i_mdm_ctrl_top (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dtr_on_i(dtr_on), .dtr_off_i(dtr_off),
    .rx_en_i(rx_en), .stat_rd_i(rd), .irq_en_i(mask), .line_n_i(lines),
    .tx_busy_i(busy), .dtr_n_o(dtr_n), .rts_n_o(rts_n), .chg_o(chg),
    .irq_o(irq), .tx_allow_o(allow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_stat();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 4'd0; dtr_on = 0; dtr_off = 0; rx_en = 0; rd = 0;
    busy = 0; mask = 4'h0; lines = 4'hF;
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1: reset state
    check(dtr_n && rts_n, "R1 reset outputs", {dtr_n, rts_n}, 3);
    check(chg == 0 && !irq, "R6 reset status", chg, 0);
    check(allow, "R11 reset allow", allow, 1);

    // R1 sweep over every mode value
    for (int m = 0; m < 16; m++) begin
      mode = 4'(m); dtr_on = 1; rx_en = 1; cyc(1); dtr_on = 0;
      check(dtr_n == (m != 3), "R1 dtr per mode", dtr_n, m != 3);
      check(rts_n == (m != 3), "R1 rts per mode", rts_n, m != 3);
      mode = 4'd3; dtr_off = 1; cyc(1); dtr_off = 0;
    end
    check(chg == 0, "R2 no flags from mode sweep", chg, 0);

    // R3 command combinations
    dtr_on = 1; dtr_off = 1; cyc(1);
    check(dtr_n == 1, "R3 both -> off", dtr_n, 1);
    dtr_off = 0; cyc(1); dtr_on = 0;
    check(dtr_n == 0, "R3 on", dtr_n, 0);
    cyc(3);
    check(dtr_n == 0, "R3 hold", dtr_n, 0);
    dtr_on = 1; dtr_off = 1; cyc(1); dtr_on = 0; dtr_off = 0;
    check(dtr_n == 1, "R3 both from on -> off", dtr_n, 1);

    // R4 RTS follows receiver enable
    rx_en = 0; cyc(1);
    check(rts_n == 1, "R4 rx off", rts_n, 1);
    rx_en = 1; cyc(1);
    check(rts_n == 0, "R4 rx on", rts_n, 0);

    // R5/R6: each line, both directions
    mask = 4'hF;
    for (int i = 0; i < 4; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        lines[i] = ~lines[i]; cyc(2);
        check(chg == 0, "R5 not before third edge", chg, 0);
        cyc(1);
        check(chg == 4'(1 << i), "R5 flag set", chg, 1 << i);
        check(irq == 1, "R8 irq with flag", irq, 1);
        cyc(2);
        check(chg == 4'(1 << i), "R6 flag sticky", chg, 1 << i);
        clear_stat();
        check(chg == 0, "R6 read clears", chg, 0);
      end
    end

    // R8 sweep: every change pattern against every mask
    for (int p = 1; p < 16; p++) begin
      lines = lines ^ 4'(p); cyc(3);
      check(chg == 4'(p), "R5 pattern flags", chg, p);
      for (int k = 0; k < 16; k++) begin
        mask = 4'(k); #2;
        check(irq == ((p & k) != 0), "R8 masked irq", irq, (p & k) != 0);
      end
      clear_stat();
    end

    // R7: change landing on the read edge is kept
    lines[1] = ~lines[1]; cyc(3);
    lines[1] = ~lines[1]; cyc(2);
    rd = 1; cyc(1); rd = 0;
    check(chg[1] == 1, "R7 change on read edge kept", chg, 2);
    clear_stat();
    check(chg == 0, "R7 later read clears", chg, 0);

    // R2: no detection outside modem mode
    mode = 4'd0; lines[2] = ~lines[2]; cyc(4);
    check(chg == 0, "R2 no flag outside mode", chg, 0);
    mode = 4'd3; cyc(3);
    check(chg == 0, "R2 no flag on entry", chg, 0);

    // R9/R10/R11 transmit gating
    lines[0] = 1'b0; cyc(3); clear_stat();
    check(allow == 1, "R9 cts active allows", allow, 1);
    busy = 1; lines[0] = 1'b1; cyc(3);
    check(allow == 1, "R10 in flight kept", allow, 1);
    cyc(5);
    check(allow == 1, "R10 still in flight", allow, 1);
    busy = 0; cyc(1);
    check(allow == 0, "R10 stop after char", allow, 0);
    lines[0] = 1'b0; cyc(2);
    check(allow == 0, "R9 not before third edge", allow, 0);
    cyc(1);
    check(allow == 1, "R9 reopen", allow, 1);
    lines[0] = 1'b1; cyc(3);
    check(allow == 0, "R9 idle stop", allow, 0);
    mode = 4'd5; cyc(1);
    check(allow == 1, "R11 open outside mode", allow, 1);
    mode = 4'd3; cyc(1);
    check(allow == 0, "R9 gated again", allow, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule